// File: doc/BRIEF.md
# Flat Page Table Address Translator

This block sits between a processor's load/store path and memory and turns each 24-bit virtual address into a 32-bit physical address. The low 13 bits pass straight through as the byte offset inside an 8 KB page. The upper 11 bits select a page. For every translated access, the block fetches one 32-bit entry from a flat table in memory, checks that entry, and returns the frame number joined to the offset, together with a fault code.

The operating system defines the current address space with three registers: a table base, a table length and a translation-enable bit. It writes them through a small configuration port and can read them back to save and restore them on a context switch. When translation is disabled, the block returns the address zero-extended and does not touch memory. When an access succeeds, the block keeps the referenced flag and the dirty flag of the entry up to date in memory. It writes the entry back only when one of those flags actually changes.

Requests and responses use a valid/ready handshake, and at most one translation is in flight at a time.

Top module: `flat_xlat`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `mem_rd_req` and `mem_wr_req` are 0, and all configuration registers read back 0.
- R2: A configuration write with `cfg_sel` = 0 (table base, 32 bits), 1 (table length, 12 bits) or 2 (bit 0 = translation enable) is visible on `cfg_rdata` in the next cycle when the same select is applied.
- R3: With translation disabled, the response carries the virtual address zero-extended to 32 bits and fault code 0, and no memory read is issued.
- R4: With translation enabled, a page number (vaddr bits 23:13) greater than or equal to the table length gives fault code 1 and physical address 0, with no memory access.
- R5: The entry is read from address base + 4 × page number, and `mem_rd_addr` is held until `mem_rd_ack`.
- R6: A successful response carries entry bits 31:13 as physical bits 31:13 and vaddr bits 12:0 as physical bits 12:0, with fault code 0.
- R7: An entry with bit 0 (valid) clear gives fault code 2 and physical address 0, with no write-back.
- R8: A write access to a valid entry with bit 1 (writable) clear gives fault code 3 and physical address 0, with no write-back.
- R9: A successful access sets bit 2 (referenced) of the entry, and a successful write access also sets bit 3 (dirty). The updated entry is written to the same address it was read from.
- R10: The entry write-back happens only when the update changes the entry. If the needed flags are already set, there is no memory write.
- R11: `req_ready` is 0 from acceptance until the response handshake completes. While `rsp_valid` is high and `rsp_ready` is low, the response fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 24 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response accepted |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 2 | 0 none, 1 out of range, 2 not present, 3 write protected |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 base, 1 length, 2 control |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Selected register value |
| mem_rd_req | output | 1 | Entry read request |
| mem_rd_addr | output | 32 | Entry read address |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_data | input | 32 | Entry read data |
| mem_wr_req | output | 1 | Entry write-back request |
| mem_wr_addr | output | 32 | Entry write-back address |
| mem_wr_data | output | 32 | Updated entry |
| mem_wr_ack | input | 1 | Write-back accepted this cycle |

## Verification
The hardest case to reach is the split between an entry that needs a write-back and one that does not. That split depends on flag state the block itself left in memory during earlier accesses. The stimulus therefore walks the same page through a load, a first store and a repeated store. Between those accesses the memory model keeps the written-back entries, so the second store must produce no memory write. A later change of the base and length registers, with entries placed at the last page of a full 2048-entry table, exercises the address formation at the top of the index range.

// File: rtl/xlat_pkg.sv
// Shared constants and types for the flat page table translator.
// Assumes the entry layout: frame in the upper bits, flags in bits 3:0.
package xlat_pkg;
    localparam int FLG_VALID = 0;
    localparam int FLG_WRITE = 1;
    localparam int FLG_REF   = 2;
    localparam int FLG_DIRTY = 3;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_RANGE = 2'd1,
        FLT_ABSENT = 2'd2,
        FLT_PROT  = 2'd3
    } fault_e;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_LEN  = 2'd1,
        SEL_CTRL = 2'd2
    } cfg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_READ = 2'd1,
        ST_WB   = 2'd2,
        ST_RESP = 2'd3
    } walk_st_e;
endpackage

// File: rtl/xlat_cfg_regs.sv
// Address-space registers: table base, table length, translation enable.
// Assumes writes land on the clock edge and reads are a plain mux.
module xlat_cfg_regs
    import xlat_pkg::*;
#(
    parameter int PA_W  = 32,
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [PA_W-1:0]  wdata,
    output logic [PA_W-1:0]  rdata,
    output logic [PA_W-1:0]  base_q,
    output logic [LEN_W-1:0] len_q,
    output logic             pg_en_q
);
    // Load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            len_q   <= '0;
            pg_en_q <= 1'b0;
        end else if (we) begin
            case (cfg_sel_e'(sel))
                SEL_BASE: base_q  <= wdata;
                SEL_LEN:  len_q   <= wdata[LEN_W-1:0];
                SEL_CTRL: pg_en_q <= wdata[0];
                default:  ;
            endcase
        end
    end

    // Read-back mux so the OS can save the registers on a context switch.
    always_comb begin
        case (cfg_sel_e'(sel))
            SEL_BASE: rdata = base_q;
            SEL_LEN:  rdata = PA_W'(len_q);
            SEL_CTRL: rdata = PA_W'(pg_en_q);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/xlat_pte_eval.sv
// Checks a fetched entry against the access kind and forms the updated entry.
// Assumes only the valid and writable flags gate the access.
module xlat_pte_eval
    import xlat_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic             is_write,
    output fault_e           fault,
    output logic [PTE_W-1:0] pte_new,
    output logic             wb_needed
);
    // Classify the access, then set the usage flags on a clean hit.
    always_comb begin
        pte_new = pte;
        if (!pte[FLG_VALID]) begin
            fault = FLT_ABSENT;
        end else if (is_write && !pte[FLG_WRITE]) begin
            fault = FLT_PROT;
        end else begin
            fault = FLT_NONE;
            pte_new[FLG_REF] = 1'b1;
            if (is_write) pte_new[FLG_DIRTY] = 1'b1;
        end
        wb_needed = (fault == FLT_NONE) && (pte_new != pte);
    end
endmodule

// File: rtl/flat_xlat.sv
// Single-level page table translator. Walks one flat in-memory table per
// access, bounded by a length register, and bypasses it when paging is off.
// Assumes one request in flight and that the OS leaves the configuration
// registers unchanged while a translation is in progress.
module flat_xlat
    import xlat_pkg::*;
#(
    parameter int VA_W  = 24,
    parameter int PA_W  = 32,
    parameter int OFF_W = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_write,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic [1:0]      rsp_fault,
    input  logic            cfg_we,
    input  logic [1:0]      cfg_sel,
    input  logic [PA_W-1:0] cfg_wdata,
    output logic [PA_W-1:0] cfg_rdata,
    output logic            mem_rd_req,
    output logic [PA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_ack,
    input  logic [PA_W-1:0] mem_rd_data,
    output logic            mem_wr_req,
    output logic [PA_W-1:0] mem_wr_addr,
    output logic [PA_W-1:0] mem_wr_data,
    input  logic            mem_wr_ack
);
    localparam int PAGE_W  = VA_W - OFF_W;
    localparam int FRAME_W = PA_W - OFF_W;
    localparam int LEN_W   = PAGE_W + 1;

    logic [PA_W-1:0]  base_q;
    logic [LEN_W-1:0] len_q;
    logic             pg_en_q;

    walk_st_e         state_q;
    logic [VA_W-1:0]  vaddr_q;
    logic             wr_q;
    logic [PA_W-1:0]  pte_q;
    logic [PA_W-1:0]  paddr_q;
    fault_e           fault_q;

    fault_e           ev_fault;
    logic [PA_W-1:0]  ev_pte;
    logic             ev_wb;

    logic [PAGE_W-1:0] in_page;
    logic [PAGE_W-1:0] cur_page;
    logic [PA_W-1:0]   entry_addr;

    xlat_cfg_regs #(.PA_W(PA_W), .LEN_W(LEN_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .sel     (cfg_sel),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .base_q  (base_q),
        .len_q   (len_q),
        .pg_en_q (pg_en_q)
    );

    xlat_pte_eval #(.PTE_W(PA_W)) u_eval (
        .pte       (mem_rd_data),
        .is_write  (wr_q),
        .fault     (ev_fault),
        .pte_new   (ev_pte),
        .wb_needed (ev_wb)
    );

    // Page index of the incoming and the held request, and the entry address.
    always_comb begin
        in_page    = req_vaddr[VA_W-1:OFF_W];
        cur_page   = vaddr_q[VA_W-1:OFF_W];
        entry_addr = base_q + (PA_W'(cur_page) << 2);
    end

    // Walk sequencer: accept, bound-check, fetch, write back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vaddr_q <= '0;
            wr_q    <= 1'b0;
            pte_q   <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (state_q)
                ST_IDLE: if (req_valid) begin
                    vaddr_q <= req_vaddr;
                    wr_q    <= req_write;
                    if (!pg_en_q) begin
                        paddr_q <= PA_W'(req_vaddr);
                        fault_q <= FLT_NONE;
                        state_q <= ST_RESP;
                    end else if (LEN_W'(in_page) >= len_q) begin
                        paddr_q <= '0;
                        fault_q <= FLT_RANGE;
                        state_q <= ST_RESP;
                    end else begin
                        state_q <= ST_READ;
                    end
                end
                ST_READ: if (mem_rd_ack) begin
                    fault_q <= ev_fault;
                    pte_q   <= ev_pte;
                    if (ev_fault != FLT_NONE) begin
                        paddr_q <= '0;
                        state_q <= ST_RESP;
                    end else begin
                        paddr_q <= {mem_rd_data[PA_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
                        state_q <= ev_wb ? ST_WB : ST_RESP;
                    end
                end
                ST_WB: if (mem_wr_ack) state_q <= ST_RESP;
                ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the sequencer state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        rsp_valid   = (state_q == ST_RESP);
        rsp_paddr   = paddr_q;
        rsp_fault   = fault_q;
        mem_rd_req  = (state_q == ST_READ);
        mem_rd_addr = entry_addr;
        mem_wr_req  = (state_q == ST_WB);
        mem_wr_addr = entry_addr;
        mem_wr_data = pte_q;
    end

    logic unused_frame_w;
    assign unused_frame_w = (FRAME_W > 0);
endmodule

// File: rtl/flat_xlat_chk.sv
// Protocol and update checks for flat_xlat, attached through bind.
// Assumes port names match the top module.
module flat_xlat_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic [1:0]      rsp_fault,
    input logic            mem_rd_req,
    input logic [PA_W-1:0] mem_rd_addr,
    input logic            mem_rd_ack,
    input logic            mem_wr_req,
    input logic [PA_W-1:0] mem_wr_data
);
    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault)); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req || mem_wr_req || rsp_valid) |-> !req_ready); // R11
    AST_RD_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req && !mem_rd_ack |=> mem_rd_req && $stable(mem_rd_addr)); // R5
    AST_WB_MARKS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_req |-> mem_wr_data[2] && mem_wr_data[0]); // R9
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && (rsp_fault != 2'd0) |-> rsp_paddr == '0); // R7
    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_req && mem_wr_req)); // R10
endmodule

bind flat_xlat flat_xlat_chk #(.PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_wr_req  (mem_wr_req),
    .mem_wr_data (mem_wr_data)
);

// File: tb/sim_flat_xlat.sv
module sim_flat_xlat;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [23:0] req_vaddr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_ack = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        mem_wr_req;
    logic [31:0] mem_wr_addr;
    logic [31:0] mem_wr_data;
    logic        mem_wr_ack = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem [logic [29:0]];
    int          n_rd, n_wr, rcnt, wcnt;
    logic [31:0] last_rd_addr, last_wr_addr, last_wr_data;

    logic [31:0] m_base = '0;
    logic [11:0] m_len = '0;
    logic        m_pg = 1'b0;

    always #10 clk = ~clk;

    flat_xlat u0 (.*);

    function automatic logic [31:0] mem_get(logic [31:0] a);
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        return 32'h0;
    endfunction

    // Memory model: acknowledges after LAT waiting cycles, stores write-backs.
    always @(negedge clk) begin
        if (mem_rd_ack) mem_rd_ack = 1'b0;
        else if (mem_rd_req) begin
            if (rcnt == LAT) begin
                mem_rd_ack = 1'b1;
                mem_rd_data = mem_get(mem_rd_addr);
                last_rd_addr = mem_rd_addr;
                n_rd++;
                rcnt = 0;
            end else rcnt++;
        end
        if (mem_wr_ack) mem_wr_ack = 1'b0;
        else if (mem_wr_req) begin
            if (wcnt == LAT) begin
                mem_wr_ack = 1'b1;
                mem[mem_wr_addr[31:2]] = mem_wr_data;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
                n_wr++;
                wcnt = 0;
            end else wcnt++;
        end
    end

    task automatic chk(string rq, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic cfg_write(logic [1:0] sel, logic [31:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        case (sel)
            2'd0: m_base = d;
            2'd1: m_len = d[11:0];
            2'd2: m_pg = d[0];
            default: ;
        endcase
    endtask

    // One translation: reference model, drive, per-clock compare, response check.
    task automatic xact(string rq, logic [23:0] va, logic wr, int hold);
        logic [10:0] pg;
        logic [31:0] ea, pte, np, e_pa, e_wd, snap;
        logic [1:0]  e_f;
        int e_rd, e_wr, guard;
        pg = va[23:13];
        ea = m_base + {19'd0, pg, 2'b00};
        e_rd = 0; e_wr = 0; e_wd = 0; e_pa = 0;
        if (!m_pg) begin
            e_f = 2'd0; e_pa = {8'h00, va};
        end else if ({1'b0, pg} >= m_len) begin
            e_f = 2'd1;
        end else begin
            e_rd = 1;
            pte = mem_get(ea);
            if (!pte[0]) e_f = 2'd2;
            else if (wr && !pte[1]) e_f = 2'd3;
            else begin
                e_f = 2'd0;
                e_pa = {pte[31:13], va[12:0]};
                np = pte | 32'h4 | (wr ? 32'h8 : 32'h0);
                if (np != pte) begin e_wr = 1; e_wd = np; end
            end
        end
        n_rd = 0; n_wr = 0; rcnt = 0; wcnt = 0;
        chk("R11", "ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (!rsp_valid && guard < 100) begin
            chk("R11", "ready while busy", {31'd0, req_ready}, 32'd0);
            @(negedge clk);
            guard++;
        end
        chk(rq, "response valid", {31'd0, rsp_valid}, 32'd1);
        chk(rq, "paddr", rsp_paddr, e_pa);
        chk(rq, "fault", {30'd0, rsp_fault}, {30'd0, e_f});
        chk(rq, "reads", n_rd, e_rd);
        if (e_rd == 1) chk("R5", "entry address", last_rd_addr, ea);
        chk(e_wr == 1 ? "R9" : "R10", "write-backs", n_wr, e_wr);
        if (e_wr == 1) begin
            chk("R9", "write-back data", last_wr_data, e_wd);
            chk("R9", "write-back address", last_wr_addr, ea);
        end
        snap = rsp_paddr;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R11", "held valid", {31'd0, rsp_valid}, 32'd1);
            chk("R11", "held paddr", rsp_paddr, snap);
        end
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R11", "valid after handshake", {31'd0, rsp_valid}, 32'd0);
        chk("R11", "ready after handshake", {31'd0, req_ready}, 32'd1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", "req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
        chk("R1", "mem_wr_req", {31'd0, mem_wr_req}, 32'd0);
        for (int s = 0; s < 3; s++) begin
            cfg_sel = 2'(s);
            #1 chk("R1", "cfg reset", cfg_rdata, 32'd0);
        end
        @(negedge clk);

        // R2 register write and read-back
        cfg_write(2'd0, 32'h0001_0000);
        cfg_write(2'd1, 32'd16);
        cfg_sel = 2'd0; #1 chk("R2", "base", cfg_rdata, 32'h0001_0000);
        cfg_sel = 2'd1; #1 chk("R2", "length", cfg_rdata, 32'd16);
        cfg_sel = 2'd2; #1 chk("R2", "control", cfg_rdata, 32'd0);
        @(negedge clk);

        // R3 pass-through when paging is off
        xact("R3", 24'hAB_CDEF, 1'b0, 0);
        xact("R3", 24'hFF_FFFF, 1'b1, 0);

        mem[30'h0001_0000 >> 2] = {19'h12345, 9'd0, 4'b0011};
        mem[30'h0001_0004 >> 2] = {19'h00ABC, 9'd0, 4'b0101};
        mem[30'h0001_0008 >> 2] = {19'h7FFFF, 9'd0, 4'b0110};
        mem[30'h0001_000C >> 2] = {19'h00001, 9'd0, 4'b1111};
        mem[30'h0001_003C >> 2] = {19'h40000, 9'd0, 4'b0001};
        cfg_write(2'd2, 32'd1);
        cfg_sel = 2'd2; #1 chk("R2", "control on", cfg_rdata, 32'd1);
        @(negedge clk);

        xact("R6", {11'd0, 13'h0123}, 1'b0, 0);   // R9 sets referenced
        xact("R9", {11'd0, 13'h1FFF}, 1'b1, 0);   // sets dirty
        xact("R10", {11'd0, 13'h0004}, 1'b1, 0);  // flags already set
        xact("R10", {11'd1, 13'h0010}, 1'b0, 2);  // read-only, R set
        xact("R8", {11'd1, 13'h0010}, 1'b1, 0);
        xact("R7", {11'd2, 13'h0000}, 1'b0, 0);
        xact("R7", {11'd2, 13'h0000}, 1'b1, 0);
        xact("R10", {11'd3, 13'h0ABC}, 1'b1, 0);
        xact("R6", {11'd15, 13'h0777}, 1'b0, 3);  // last in-range page
        xact("R4", {11'd16, 13'h0000}, 1'b0, 0);
        xact("R4", {11'h7FF, 13'h1234}, 1'b1, 1);

        // Context switch: new base, full-size table
        cfg_write(2'd0, 32'h0002_0000);
        cfg_write(2'd1, 32'd2048);
        mem[(32'h0002_0000 + 32'h1FFC) >> 2] = {19'h5A5A5, 9'd0, 4'b0011};
        mem[32'h0002_0000 >> 2] = {19'h00002, 9'd0, 4'b0001};
        xact("R5", {11'h7FF, 13'h0001}, 1'b1, 0);
        xact("R5", {11'd0, 13'h0002}, 1'b0, 0);

        cfg_write(2'd2, 32'd0);
        xact("R3", {11'h7FF, 13'h0001}, 1'b0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule